// File: doc/BRIEF.md
# Pseudo-Random Noise Bit Source

This block produces a single pseudo-random bit that serves as the white-noise source of a percussion voice. A free-running interval counter, clocked by the system clock, raises a one-cycle step pulse once every `STEP_CYCLES` clocks. On each step pulse the shift register advances by one position, and the bit it shifts out is captured into the output register. The interval is programmable. Choosing a few tens of microseconds sets the rate at which the noise bit can change, and so its bandwidth.

Two register structures are available, chosen by `mode_sel`. The first is a 16-bit shift register with external feedback. The second is a 32-bit register with internal XOR taps. The structure is latched only at reset or at a seed load, so a sequence in progress never changes structure. A seed can be loaded at any time. A register that holds all zeros is detected and reseeded, so the sequence cannot stall.

Top module: `noise_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `noise_out` to 0, restarts the interval count, latches `mode_sel` as the structure, and loads that structure's default seed. The 32-bit default is 0xFEEDFACE and the 16-bit default is `FIB_SEED`.
- R2: `step_pulse` is high for exactly one clock in every `STEP_CYCLES` clocks. The first pulse comes in the `STEP_CYCLES`-th cycle after reset or seed load is released.
- R3: With `mode_sel`=1 latched (32-bit structure), a step shifts the register right by one. If the bit shifted out was 1, the result is XORed with a mask that has bits 31, 15, 2 and 1 set.
- R4: On a step, `noise_out` takes bit 0 of the register as it was before the shift. This applies in both structures.
- R5: With `mode_sel`=0 latched (16-bit structure), the feedback is the XOR of bits 0, 2, 3 and 5. The register shifts right by one and the feedback enters bit 15.
- R6: `noise_out` changes only on the clock edge that ends a cycle in which `step_pulse` is high, or on reset.
- R7: When `seed_load` is high at a clock edge, the block loads `seed_value` into the register and latches `mode_sel`. In the 16-bit structure only bits 15:0 of `seed_value` are used. The same edge restarts the interval count and leaves `noise_out` unchanged. `seed_load` takes priority over a step.
- R8: If the register holds all zeros when a step occurs, the register is loaded with the default seed of the latched structure instead of shifting, and `noise_out` becomes 0.
- R9: A change of `mode_sel` while neither `rst` nor `seed_load` is high has no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Structure select: 0 = 16-bit external feedback, 1 = 32-bit internal taps |
| seed_load | input | 1 | Load `seed_value` and latch `mode_sel` |
| seed_value | input | 32 | Seed to load |
| noise_out | output | 1 | Registered noise bit |
| step_pulse | output | 1 | One-cycle pulse marking each register step |

## Verification
The hardest situation to reach from the ports is the all-zero register, because neither structure ever steps into that state on its own. The stimulus forces it by loading a zero seed in each structure, then checks the reseed and the zero output bit on the next step. Random stimulus also loads zero seeds at random points, toggles `mode_sel` on nearly every cycle without a load, and places some loads in the same cycle as a step pulse.

// File: rtl/noise_pkg.sv
package noise_pkg;

    typedef enum logic {
        KIND_FIB = 1'b0,
        KIND_GAL = 1'b1
    } lfsr_kind_e;

    typedef struct packed {
        lfsr_kind_e  kind;
        logic [31:0] bits;
    } lfsr_state_t;

    localparam int FIB_W = 16;
    localparam int GAL_W = 32;
    localparam logic [GAL_W-1:0] GAL_TAP_MASK = 32'h8000_8006;

    function automatic logic [GAL_W-1:0] gal_advance(input logic [GAL_W-1:0] s);
        logic [GAL_W-1:0] shifted;
        shifted = s >> 1;
        return s[0] ? (shifted ^ GAL_TAP_MASK) : shifted;
    endfunction

    function automatic logic [FIB_W-1:0] fib_advance(input logic [FIB_W-1:0] s);
        logic fb;
        fb = s[0] ^ s[2] ^ s[3] ^ s[5];
        return {fb, s[FIB_W-1:1]};
    endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
    parameter int STEP_CYCLES = 10050
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic strobe
);
    localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] count_q;

    assign strobe = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || strobe) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !restart) |=> !strobe);

endmodule

// File: rtl/lfsr_core.sv
module lfsr_core
    import noise_pkg::*;
#(
    parameter logic [FIB_W-1:0] FIB_SEED = 16'hACE1,
    parameter logic [GAL_W-1:0] GAL_SEED = 32'hFEED_FACE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        kind_in,
    input  logic        load,
    input  logic [31:0] load_value,
    input  logic        advance,
    output logic        tap_bit
);
    lfsr_state_t st_q;
    lfsr_state_t st_d;

    function automatic logic [31:0] default_seed(input lfsr_kind_e k);
        return (k == KIND_GAL) ? GAL_SEED : {16'h0, FIB_SEED};
    endfunction

    assign tap_bit = st_q.bits[0];

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.kind = lfsr_kind_e'(kind_in);
            st_d.bits = default_seed(lfsr_kind_e'(kind_in));
        end else if (load) begin
            st_d.kind = lfsr_kind_e'(kind_in);
            st_d.bits = (lfsr_kind_e'(kind_in) == KIND_GAL) ? load_value
                                                           : {16'h0, load_value[15:0]};
        end else if (advance) begin
            if (st_q.bits == '0) begin
                st_d.bits = default_seed(st_q.kind);
            end else if (st_q.kind == KIND_GAL) begin
                st_d.bits = gal_advance(st_q.bits);
            end else begin
                st_d.bits = {16'h0, fib_advance(st_q.bits[15:0])};
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R9
    kind_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(st_q.kind));

    // R8
    zero_reseed_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && st_q.bits == '0) |=> (st_q.bits == default_seed(st_q.kind)));

    // R5
    fib_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.kind == KIND_FIB) |-> (st_q.bits[31:16] == 16'h0));

    // R3
    gal_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && st_q.kind == KIND_GAL && st_q.bits != '0) |=> (st_q.bits != '0));

endmodule

// File: rtl/noise_gen.sv
module noise_gen
    import noise_pkg::*;
#(
    parameter int               STEP_CYCLES = 10050,
    parameter logic [FIB_W-1:0] FIB_SEED    = 16'hACE1,
    parameter logic [GAL_W-1:0] GAL_SEED    = 32'hFEED_FACE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_sel,
    input  logic        seed_load,
    input  logic [31:0] seed_value,
    output logic        noise_out,
    output logic        step_pulse
);
    logic strobe;
    logic tap_bit;
    logic noise_q;

    step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (seed_load),
        .strobe  (strobe)
    );

    lfsr_core #(.FIB_SEED(FIB_SEED), .GAL_SEED(GAL_SEED)) u_core (
        .clk        (clk),
        .rst        (rst),
        .kind_in    (mode_sel),
        .load       (seed_load),
        .load_value (seed_value),
        .advance    (strobe),
        .tap_bit    (tap_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            noise_q <= 1'b0;
        end else if (strobe && !seed_load) begin
            noise_q <= tap_bit;
        end
    end

    assign noise_out  = noise_q;
    assign step_pulse = strobe;

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe || seed_load) |=> $stable(noise_q));

endmodule

// File: tb/noise_gen_bench.sv
module noise_gen_bench;
    localparam int N = 4;
    localparam logic [15:0] FSEED = 16'hACE1;
    localparam logic [31:0] GSEED = 32'hFEEDFACE;

    logic clk = 1'b0;
    logic rst = 1'b1, mode_sel = 1'b1, seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic noise_out, step_pulse;

    int checks = 0, failures = 0;

    logic        m_kind;
    logic [31:0] m_bits;
    int          m_cnt;
    logic        m_out;

    always #2.5 clk = ~clk;

    noise_gen #(.STEP_CYCLES(N), .FIB_SEED(FSEED), .GAL_SEED(GSEED)) u_noise_gen (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .seed_load(seed_load),
        .seed_value(seed_value), .noise_out(noise_out), .step_pulse(step_pulse)
    );

    function automatic logic [31:0] ref_gal(input logic [31:0] s);
        logic [31:0] r;
        r = {1'b0, s[31:1]};
        if (s[0]) begin
            r[31] = ~r[31]; r[15] = ~r[15]; r[2] = ~r[2]; r[1] = ~r[1];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_fib(input logic [31:0] s);
        return {16'h0, s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    function automatic logic [31:0] ref_default(input logic k);
        return k ? GSEED : {16'h0, FSEED};
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic r, input logic ld, input logic md,
                         input logic [31:0] sv, input string tag);
        logic stb;
        @(negedge clk);
        rst = r; seed_load = ld; mode_sel = md; seed_value = sv;
        @(posedge clk);
        if (r) begin
            m_cnt = 0; m_kind = md; m_bits = ref_default(md); m_out = 1'b0;
        end else if (ld) begin
            m_cnt = 0; m_kind = md;
            m_bits = md ? sv : {16'h0, sv[15:0]};
        end else begin
            stb = (m_cnt == N - 1);
            m_cnt = stb ? 0 : m_cnt + 1;
            if (stb) begin
                m_out = m_bits[0];
                if (m_bits == 0) m_bits = ref_default(m_kind);
                else m_bits = m_kind ? ref_gal(m_bits) : ref_fib(m_bits);
            end
        end
        #1;
        check(noise_out, m_out, tag);
        check(step_pulse, (m_cnt == N - 1), "R2 step_pulse");
    endtask

    initial begin
        #(5ns * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        // R1 reset state, 32-bit structure
        cycle(1, 0, 1, 0, "R1 reset");
        cycle(1, 0, 1, 0, "R1 reset");
        // R3 R4 default 32-bit sequence
        for (int i = 0; i < 200; i++) cycle(0, 0, 1, 0, "R3 R4 gal default");
        // R9 toggle mode without load
        for (int i = 0; i < 120; i++) cycle(0, 0, i[0], 0, "R9 mode ignored");
        // R8 zero seed in 32-bit structure
        cycle(0, 1, 1, 32'h0, "R7 load zero");
        for (int i = 0; i < 60; i++) cycle(0, 0, 1, 0, "R8 gal zero reseed");
        // R1 R5 reset into 16-bit structure
        cycle(1, 0, 0, 0, "R1 reset fib");
        for (int i = 0; i < 200; i++) cycle(0, 0, 0, 0, "R5 fib default");
        // R8 zero seed in 16-bit structure (upper bits ignored)
        cycle(0, 1, 0, 32'hABCD_0000, "R7 load fib zero");
        for (int i = 0; i < 60; i++) cycle(0, 0, 0, 0, "R8 fib zero reseed");
        // R7 load during a step cycle
        while (m_cnt != N - 2) cycle(0, 0, 0, 0, "R6 align");
        cycle(0, 1, 1, 32'h1234_5679, "R7 load on step");
        for (int i = 0; i < 40; i++) cycle(0, 0, 0, 0, "R7 after load");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic ld, md;
            logic [31:0] sv;
            ld = ($urandom % 60) == 0;
            md = $urandom % 2;
            sv = (($urandom % 4) == 0) ? 32'h0 : $urandom;
            cycle(0, ld, md, sv, ld ? "R7 random load" : "R6 R9 random run");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule